// File: doc/BRIEF.md
# Mixed-Radix Receive-Delay Position Accumulator

This block keeps one receive-enable delay setting as a positional number whose digits have different radices. The most significant digit is a coarse clock count. Below it sits a half-phase digit that only takes even values below four. Next comes a tap digit, and the least significant digit is a fine step. The tap and fine radices are not fixed. They are latched from a speed-grade input whenever the position is loaded.

A search engine outside the block issues one command at a time: load, quarter step forward or back, fine step, half backstep, full backstep, tap add, or preamble shift. The command is applied in one clock. The block then walks carries and borrows up through the digits, one digit adjustment per clock, and pulses `done` once every digit is back in range. If the coarse digit ends outside 0..15, a sticky error is raised and the coarse value saturates. The digits are always presented packed into two register-layout words: a per-group timing word and a per-channel coarse word.

Top module: `dpa_accum`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` and `coarse_err` are 0, and both packed words are 0.
- R2: Command code 0 (load) sets the coarse digit to `cmd_arg` and clears the phase, tap, fine and preamble digits and the error. It latches a tap bound of 9 and a fine bound of 8 when `speed_fast` is 1, and a tap bound of 12 and a fine bound of 1 otherwise.
- R3: Command code 1 (quarter step) adds tap_bound>>1 to the tap digit, plus (pb>>1) to the fine digit when the tap bound is odd. Command code 2 (quarter backstep) subtracts the same amounts.
- R4: Command code 3 adds 1 to the fine digit. Code 4 subtracts 2 from the phase digit. Code 5 subtracts 1 from the coarse digit. Code 6 adds `cmd_arg` to the tap digit.
- R5: Normalisation wraps the fine digit at the fine bound into the tap digit (±1). It wraps the tap digit at the tap bound into the phase digit (±2). It wraps the phase digit at 4 into the coarse digit (±1). After `done`, every digit is in range and the phase digit is even.
- R6: An accepted command drops `cmd_ready`. `done` is a one-cycle pulse that comes exactly n+1 clocks after the accepting edge, where n is the number of digit adjustments needed.
- R7: A command presented while `cmd_ready` is 0 is ignored.
- R8: If the normalised coarse digit is below 0 or above 15, `coarse_err` is set and the coarse digit saturates to 0 or 15. `coarse_err` then stays set until the next load.
- R9: Command code 7 (preamble shift) writes `cmd_arg[1:0]` into the preamble digit and subtracts the same amount from the coarse digit.
- R10: `grp_word` carries the tap digit in bits 31:28, the fine digit in bits 26:24, the phase digit in bits 23:22 and the preamble in bits 21:20. `chan_word` carries the coarse digit in bits 10:7. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 4 | Command operand (coarse value, tap amount or preamble amount) |
| speed_fast | input | 1 | Speed grade, sampled on load |
| cmd_ready | output | 1 | High when a command can be accepted |
| done | output | 1 | One-cycle pulse when normalisation finishes |
| coarse_err | output | 1 | Sticky coarse range error |
| grp_word | output | 32 | Packed per-group timing word |
| chan_word | output | 32 | Packed per-channel coarse word |

## Verification
The assertions assume that the search engine starts from a load. They also assume that any single command moves a digit by less than the internal signed accumulator can hold, which the 4-bit operand and 8-bit accumulators guarantee. The stimulus starts every sweep pair with a load and keeps tap additions at or below 15. It also holds `cmd_valid` through a busy window to show that such a command is dropped. A reference model in the bench counts the carry and borrow iterations, so it predicts both the packed words and the exact clock of `done`.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   localparam int ACC_W = 8;

   typedef logic signed [ACC_W-1:0] acc_t;

   typedef enum logic [2:0] {
      OP_LOAD   = 3'd0,
      OP_QSTEP  = 3'd1,
      OP_QBACK  = 3'd2,
      OP_PSTEP  = 3'd3,
      OP_HBACK  = 3'd4,
      OP_CBACK  = 3'd5,
      OP_TADD   = 3'd6,
      OP_PSHIFT = 3'd7
   } dpa_op_e;

   typedef struct packed {
      acc_t c;
      acc_t ph;
      acc_t t;
      acc_t p;
      acc_t pre;
   } dpa_pos_t;
endpackage

// File: rtl/dpa_step.sv
module dpa_step
   import dpa_pkg::*;
#(
   parameter int ARG_W        = 4,
   parameter int PRE_W        = 2,
   parameter int PH_STEP      = 2,
   parameter int T_BOUND_FAST = 9,
   parameter int P_BOUND_FAST = 8,
   parameter int T_BOUND_SLOW = 12,
   parameter int P_BOUND_SLOW = 1,
   parameter bit QUARTER_SPILL = 1'b1
) (
   input  dpa_pos_t           pos_i,
   input  acc_t               tb_i,
   input  acc_t               pb_i,
   input  logic [2:0]         op_i,
   input  logic [ARG_W-1:0]   arg_i,
   input  logic               fast_i,
   output dpa_pos_t           pos_o,
   output acc_t               tb_o,
   output acc_t               pb_o
);
   acc_t q_t;
   acc_t q_p;
   acc_t arg_a;
   acc_t pre_amt;
   dpa_op_e op;

   assign op      = dpa_op_e'(op_i);
   assign q_t     = tb_i >>> 1;
   assign arg_a   = acc_t'(arg_i);
   assign pre_amt = acc_t'(arg_i[PRE_W-1:0]);

   generate
      if (QUARTER_SPILL) begin : g_spill
         assign q_p = tb_i[0] ? (pb_i >>> 1) : '0;
      end else begin : g_nospill
         assign q_p = '0;
      end
   endgenerate

   always_comb begin
      pos_o = pos_i;
      tb_o  = tb_i;
      pb_o  = pb_i;
      case (op)
         OP_LOAD: begin
            pos_o   = '0;
            pos_o.c = arg_a;
            tb_o    = fast_i ? acc_t'(T_BOUND_FAST) : acc_t'(T_BOUND_SLOW);
            pb_o    = fast_i ? acc_t'(P_BOUND_FAST) : acc_t'(P_BOUND_SLOW);
         end
         OP_QSTEP: begin
            pos_o.t = pos_i.t + q_t;
            pos_o.p = pos_i.p + q_p;
         end
         OP_QBACK: begin
            pos_o.t = pos_i.t - q_t;
            pos_o.p = pos_i.p - q_p;
         end
         OP_PSTEP:  pos_o.p = pos_i.p + acc_t'(1);
         OP_HBACK:  pos_o.ph = pos_i.ph - acc_t'(PH_STEP);
         OP_CBACK:  pos_o.c = pos_i.c - acc_t'(1);
         OP_TADD:   pos_o.t = pos_i.t + arg_a;
         OP_PSHIFT: begin
            pos_o.pre = pre_amt;
            pos_o.c   = pos_i.c - pre_amt;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dpa_norm.sv
module dpa_norm
   import dpa_pkg::*;
#(
   parameter int PH_BOUND = 4,
   parameter int PH_STEP  = 2
) (
   input  dpa_pos_t pos_i,
   input  acc_t     tb_i,
   input  acc_t     pb_i,
   output dpa_pos_t pos_o,
   output logic     settled_o
);
   localparam acc_t PHB = acc_t'(PH_BOUND);
   localparam acc_t PHS = acc_t'(PH_STEP);

   // One digit adjustment per evaluation, lowest digit first.
   always_comb begin
      pos_o     = pos_i;
      settled_o = 1'b0;
      if (pos_i.p >= pb_i) begin
         pos_o.p = pos_i.p - pb_i;
         pos_o.t = pos_i.t + acc_t'(1);
      end else if (pos_i.p < 0) begin
         pos_o.p = pos_i.p + pb_i;
         pos_o.t = pos_i.t - acc_t'(1);
      end else if (pos_i.t >= tb_i) begin
         pos_o.t  = pos_i.t - tb_i;
         pos_o.ph = pos_i.ph + PHS;
      end else if (pos_i.t < 0) begin
         pos_o.t  = pos_i.t + tb_i;
         pos_o.ph = pos_i.ph - PHS;
      end else if (pos_i.ph >= PHB) begin
         pos_o.ph = pos_i.ph - PHB;
         pos_o.c  = pos_i.c + acc_t'(1);
      end else if (pos_i.ph < 0) begin
         pos_o.ph = pos_i.ph + PHB;
         pos_o.c  = pos_i.c - acc_t'(1);
      end else begin
         settled_o = 1'b1;
      end
   end
endmodule

// File: rtl/dpa_pack.sv
module dpa_pack
   import dpa_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int C_W     = 4,
   parameter int PH_W    = 2,
   parameter int T_W     = 4,
   parameter int P_W     = 3,
   parameter int PRE_W   = 2,
   parameter int T_LSB   = 28,
   parameter int P_LSB   = 24,
   parameter int PH_LSB  = 22,
   parameter int PRE_LSB = 20,
   parameter int C_LSB   = 7
) (
   input  dpa_pos_t          pos_i,
   output logic [WORD_W-1:0] grp_o,
   output logic [WORD_W-1:0] chan_o
);
   logic unused_hi;
   assign unused_hi = ^{pos_i.c[ACC_W-1:C_W], pos_i.ph[ACC_W-1:PH_W],
                        pos_i.t[ACC_W-1:T_W], pos_i.p[ACC_W-1:P_W],
                        pos_i.pre[ACC_W-1:PRE_W]};

   always_comb begin
      grp_o = '0;
      grp_o[T_LSB +: T_W]     = pos_i.t[T_W-1:0];
      grp_o[P_LSB +: P_W]     = pos_i.p[P_W-1:0];
      grp_o[PH_LSB +: PH_W]   = pos_i.ph[PH_W-1:0];
      grp_o[PRE_LSB +: PRE_W] = pos_i.pre[PRE_W-1:0];
      chan_o = '0;
      chan_o[C_LSB +: C_W]    = pos_i.c[C_W-1:0];
   end
endmodule

// File: rtl/dpa_accum.sv
module dpa_accum
   import dpa_pkg::*;
#(
   parameter int WORD_W        = 32,
   parameter int ARG_W         = 4,
   parameter int C_W           = 4,
   parameter int PH_W          = 2,
   parameter int T_W           = 4,
   parameter int P_W           = 3,
   parameter int PRE_W         = 2,
   parameter int PH_BOUND      = 4,
   parameter int PH_STEP       = 2,
   parameter int T_BOUND_FAST  = 9,
   parameter int P_BOUND_FAST  = 8,
   parameter int T_BOUND_SLOW  = 12,
   parameter int P_BOUND_SLOW  = 1,
   parameter bit QUARTER_SPILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ARG_W-1:0]  cmd_arg,
   input  logic              speed_fast,
   output logic              cmd_ready,
   output logic              done,
   output logic              coarse_err,
   output logic [WORD_W-1:0] grp_word,
   output logic [WORD_W-1:0] chan_word
);
   localparam int   C_MAX  = (1 << C_W) - 1;
   localparam acc_t C_HI   = acc_t'(C_MAX);

   generate
      if (T_BOUND_FAST > (1 << T_W) || T_BOUND_SLOW > (1 << T_W))
         $error("tap bound exceeds tap field width");
      if (P_BOUND_FAST > (1 << P_W) || P_BOUND_SLOW > (1 << P_W))
         $error("fine bound exceeds fine field width");
      if (PH_BOUND > (1 << PH_W) || PH_STEP >= PH_BOUND)
         $error("phase bound or step inconsistent");
      if (C_W + 2 >= ACC_W || T_W + 2 >= ACC_W || ARG_W + 2 >= ACC_W)
         $error("accumulator too narrow for field widths");
      if (PRE_W > ARG_W)
         $error("preamble width exceeds operand width");
   endgenerate

   dpa_pos_t pos_q, step_pos, norm_pos;
   acc_t     tb_q, pb_q, step_tb, step_pb;
   logic     busy_q, done_q, err_q, settled;
   logic     accept;

   assign accept = cmd_valid && !busy_q;

   dpa_step #(
      .ARG_W(ARG_W), .PRE_W(PRE_W), .PH_STEP(PH_STEP),
      .T_BOUND_FAST(T_BOUND_FAST), .P_BOUND_FAST(P_BOUND_FAST),
      .T_BOUND_SLOW(T_BOUND_SLOW), .P_BOUND_SLOW(P_BOUND_SLOW),
      .QUARTER_SPILL(QUARTER_SPILL)
   ) u_step (
      .pos_i(pos_q), .tb_i(tb_q), .pb_i(pb_q),
      .op_i(cmd_op), .arg_i(cmd_arg), .fast_i(speed_fast),
      .pos_o(step_pos), .tb_o(step_tb), .pb_o(step_pb)
   );

   dpa_norm #(
      .PH_BOUND(PH_BOUND), .PH_STEP(PH_STEP)
   ) u_norm (
      .pos_i(pos_q), .tb_i(tb_q), .pb_i(pb_q),
      .pos_o(norm_pos), .settled_o(settled)
   );

   dpa_pack #(
      .WORD_W(WORD_W), .C_W(C_W), .PH_W(PH_W), .T_W(T_W),
      .P_W(P_W), .PRE_W(PRE_W)
   ) u_pack (
      .pos_i(pos_q), .grp_o(grp_word), .chan_o(chan_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= '0;
         tb_q   <= acc_t'(T_BOUND_SLOW);
         pb_q   <= acc_t'(P_BOUND_SLOW);
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (!busy_q) begin
         done_q <= 1'b0;
         if (cmd_valid) begin
            pos_q  <= step_pos;
            tb_q   <= step_tb;
            pb_q   <= step_pb;
            busy_q <= 1'b1;
            if (dpa_op_e'(cmd_op) == OP_LOAD) err_q <= 1'b0;
         end
      end else if (!settled) begin
         pos_q <= norm_pos;
      end else begin
         busy_q <= 1'b0;
         done_q <= 1'b1;
         if (pos_q.c < 0) begin
            pos_q.c <= '0;
            err_q   <= 1'b1;
         end else if (pos_q.c > C_HI) begin
            pos_q.c <= C_HI;
            err_q   <= 1'b1;
         end
      end
   end

   assign cmd_ready  = !busy_q;
   assign done       = done_q;
   assign coarse_err = err_q;

   // Digits are in range whenever normalisation reports completion.
   assert_done_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pos_q.t >= 0 && pos_q.t < tb_q && pos_q.p >= 0 &&
                pos_q.p < pb_q && (pos_q.ph == 0 || pos_q.ph == acc_t'(PH_STEP))));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   // A load during busy would otherwise reload the bounds.
   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> ($stable(tb_q) && $stable(pb_q)));

   assert_coarse_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pos_q.c >= 0 && pos_q.c <= C_HI));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (coarse_err && !(accept && dpa_op_e'(cmd_op) == OP_LOAD)) |=> coarse_err);

   assert_pre_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(pos_q.pre));
endmodule

// File: tb/dpa_accum_test.sv
module dpa_accum_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [3:0]  cmd_arg = '0;
   logic        speed_fast = 1'b0;
   logic        cmd_ready, done, coarse_err;
   logic [31:0] grp_word, chan_word;

   int checks = 0;
   int fails  = 0;
   int m_c = 0, m_ph = 0, m_t = 0, m_p = 0, m_pre = 0, m_tb = 12, m_pb = 1;
   bit m_err = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   dpa_accum uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .speed_fast(speed_fast), .cmd_ready(cmd_ready),
      .done(done), .coarse_err(coarse_err), .grp_word(grp_word),
      .chan_word(chan_word)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string op_tag(input int op);
      case (op)
         0: return "R2";
         1, 2: return "R3";
         7: return "R9";
         default: return "R4";
      endcase
   endfunction

   task automatic model(input int op, input int arg, input bit fast, output int n);
      case (op)
         0: begin
            m_c = arg; m_ph = 0; m_t = 0; m_p = 0; m_pre = 0; m_err = 1'b0;
            m_tb = fast ? 9 : 12; m_pb = fast ? 8 : 1;
         end
         1: begin m_t += m_tb / 2; m_p += (m_tb % 2) * (m_pb / 2); end
         2: begin m_t -= m_tb / 2; m_p -= (m_tb % 2) * (m_pb / 2); end
         3: m_p += 1;
         4: m_ph -= 2;
         5: m_c -= 1;
         6: m_t += arg;
         default: begin m_pre = arg % 4; m_c -= arg % 4; end
      endcase
      n = 0;
      while (m_p >= m_pb) begin m_p -= m_pb; m_t++; n++; end
      while (m_p < 0)     begin m_p += m_pb; m_t--; n++; end
      while (m_t >= m_tb) begin m_t -= m_tb; m_ph += 2; n++; end
      while (m_t < 0)     begin m_t += m_tb; m_ph -= 2; n++; end
      while (m_ph >= 4)   begin m_ph -= 4; m_c++; n++; end
      while (m_ph < 0)    begin m_ph += 4; m_c--; n++; end
      if (m_c < 0) begin m_c = 0; m_err = 1'b1; end
      else if (m_c > 15) begin m_c = 15; m_err = 1'b1; end
   endtask

   function automatic logic [31:0] exp_grp();
      return (32'(m_t) << 28) | (32'(m_p) << 24) | (32'(m_ph) << 22) | (32'(m_pre) << 20);
   endfunction

   function automatic logic [31:0] exp_chan();
      return 32'(m_c) << 7;
   endfunction

   // Issues one command; optionally holds an intruding command through the busy window.
   task automatic run_cmd(input int op, input int arg, input bit fast, input bit intrude);
      int n;
      int lat;
      string tg;
      tg = op_tag(op);
      model(op, arg, fast, n);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = 4'(arg); speed_fast = fast;
      @(posedge clk);
      @(negedge clk);
      if (intrude) begin
         cmd_op = 3'd0; cmd_arg = 4'd2; speed_fast = ~fast;
      end else begin
         cmd_valid = 1'b0;
      end
      check(cmd_ready == 1'b0, "R6", "ready while busy", cmd_ready, 0);
      lat = 0;
      do begin
         @(posedge clk);
         @(negedge clk);
         cmd_valid = 1'b0;
         lat++;
      end while (!done && lat < 64);
      check(lat == n + 1, "R6", "done latency", lat, n + 1);
      check(grp_word == exp_grp(), intrude ? "R7" : tg, "grp word R5 R10", grp_word, exp_grp());
      check(chan_word == exp_chan(), intrude ? "R7" : tg, "chan word R5 R10", chan_word, exp_chan());
      check(coarse_err == m_err, "R8", "coarse error", coarse_err, m_err);
      @(posedge clk);
      @(negedge clk);
      check(done == 1'b0, "R6", "done width", done, 0);
   endtask

   initial begin
      #(8 * 190000);
      fails++;
      $display("FAIL R6 watchdog expired: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
      check(done == 1'b0, "R1", "done after reset", done, 0);
      check(coarse_err == 1'b0, "R1", "err after reset", coarse_err, 0);
      check(grp_word == 32'h0, "R1", "grp after reset", grp_word, 0);
      check(chan_word == 32'h0, "R1", "chan after reset", chan_word, 0);

      // R10 literal layout: fast quarter step gives t=4, p=4
      run_cmd(0, 9, 1'b1, 1'b0);
      run_cmd(1, 0, 1'b1, 1'b0);
      check(grp_word == 32'h4400_0000, "R10", "packed fast quarter", grp_word, 32'h4400_0000);
      check(chan_word == 32'h0000_0480, "R10", "packed coarse 9", chan_word, 32'h480);

      // R5 literal tap carry into phase: slow, t=12 wraps to 0, ph=2
      run_cmd(0, 3, 1'b0, 1'b0);
      run_cmd(6, 12, 1'b0, 1'b0);
      check(grp_word == 32'h0080_0000, "R5", "tap carry to phase", grp_word, 32'h0080_0000);
      run_cmd(9 - 2 - 3, 0, 1'b0, 1'b0);
      check(grp_word == 32'h0, "R4", "half backstep", grp_word, 0);

      // R8 overflow through phase carry, then stickiness, then load clears
      run_cmd(0, 15, 1'b0, 1'b0);
      run_cmd(6, 12, 1'b0, 1'b0);
      run_cmd(6, 12, 1'b0, 1'b0);
      check(coarse_err == 1'b1, "R8", "overflow flagged", coarse_err, 1);
      check(chan_word == 32'h780, "R8", "saturated high", chan_word, 32'h780);
      run_cmd(3, 0, 1'b0, 1'b0);
      check(coarse_err == 1'b1, "R8", "error sticky", coarse_err, 1);
      run_cmd(0, 0, 1'b0, 1'b0);
      run_cmd(5, 0, 1'b0, 1'b0);
      check(chan_word == 32'h0, "R8", "saturated low", chan_word, 0);

      // R7 intrusion: command held during busy window is dropped
      run_cmd(0, 5, 1'b0, 1'b0);
      run_cmd(3, 0, 1'b0, 1'b1);
      run_cmd(2, 0, 1'b1, 1'b1);

      // Sweep: every load value, speed, command and several operands
      for (int f = 0; f < 2; f++)
         for (int c0 = 0; c0 < 16; c0++)
            for (int op = 0; op < 8; op++)
               for (int a = 0; a < 5; a++) begin
                  run_cmd(0, c0, f[0], 1'b0);
                  run_cmd(op, (a == 4) ? 15 : a, f[0], 1'b0);
               end

      // Long chained sequences from a pseudo-random source
      for (int k = 0; k < 600; k++) begin
         int op;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         op = int'(lfsr[2:0]);
         if (op == 0 && lfsr[8]) op = 3;
         run_cmd(op, int'(lfsr[6:3]), lfsr[7], 1'b0);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule